// File: doc/BRIEF.md
# Per-Pad I/O Multiplexer with Auxiliary Core Ports

This block sits between 126 chip pads and the logic that wants to use them. The pads come in six banks of 16, 28, 24, 24, 24 and 10 pins, lettered A to F. Each pad carries a three-bit source select, held in configuration registers written over a plain word-addressed register bus. The select picks one of eight sources for the pad's output value and output enable: the plain GPIO block, one of three peripheral functions, or one of four small auxiliary I/O cores. The block also routes the pad's input level back to whichever consumer owns it.

Every auxiliary core sees a flat 28-bit port. Banks B to E place their pin n at core index n. The two short banks share one port: A fills indices 0 to 15 and F continues at 16 to 25. Software can therefore assemble a contiguous bus of up to 28 bits for one core, for example a 24-bit parallel pixel bus, by picking pins from several banks. When two pads that map to the same core index both select that core, the input side resolves the clash by bank letter.

Top module: `pinmux_top`

## Requirements
- R1: After reset every pad select is 0, so every register reads back 0. Every pad is driven from the GPIO path, and padOe is all zero while gpioOe is zero.
- R2: Word address g holds the selects of pads 8g to 8g+7. Pad 8g+i uses nibble i, with its select in bits [4i+2:4i]. Bit 4i+3 is reserved: it reads 0 whatever was written. A write changes the selects at the clock edge that samples cfgWe. Read data is combinational from the address.
- R3: In the last register (address 15), nibbles 6 and 7 have no pad behind them. They always read 0 and writes to them have no effect.
- R4: Select 0 drives padOut/padOe from gpioOut/gpioOe at the same pad index. gpioIn always equals padIn, whatever the select.
- R5: Select 1, 2 or 3 picks peripheral function f = select-1. The pad takes perOut/perOe bit f*126+p. perIn bit f*126+p equals padIn[p] when pad p selects function f, and is 0 otherwise.
- R6: Select 4 to 7 picks core c = select-4. The pad takes coreOut/coreOe bit c*28+k, where k is the pad's core index.
- R7: Pads are numbered A0-A15 = 0..15, B = 16..43, C = 44..67, D = 68..91, E = 92..115 and F = 116..125. Pin n of B, C, D or E and pin n of A map to core index n. Pin n of F maps to core index 16+n.
- R8: coreIn bit c*28+k reads the pad of the lowest-lettered bank that maps to index k and selects core c. If no pad does, the bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration word address (group of eight pads) |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Selects of the addressed group, reserved bits 0 |
| gpioOut | input | 126 | GPIO output values, one per pad |
| gpioOe | input | 126 | GPIO output enables, one per pad |
| gpioIn | output | 126 | Pad levels toward the GPIO block |
| perOut | input | 378 | Peripheral output values, function-major |
| perOe | input | 378 | Peripheral output enables, function-major |
| perIn | output | 378 | Pad levels toward peripheral functions, gated by select |
| coreOut | input | 112 | Auxiliary core port output values, core-major |
| coreOe | input | 112 | Auxiliary core port output enables, core-major |
| coreIn | output | 112 | Auxiliary core port input levels, core-major |
| padIn | input | 126 | Pad input levels |
| padOut | output | 126 | Pad output values |
| padOe | output | 126 | Pad output enables |

## Verification
The sharpest case is several pads from different banks claiming the same core index. A design that resolved the clash by the highest pad number, or that ORed the claimants, would show the wrong bank's level on coreIn. The fold of bank F onto indices 16 to 25 and the B-only indices 26 and 27 are checked on both the output and input side. A design that treated F like the other banks would drive F pads from core bits 0 to 9. A core that no pad selects must read all zero even with every pad high. The register checks look at three things: read data before and after the write edge, to catch a design that is a cycle early or late; reserved bits written as ones; and the two missing pads in the last register. Random select patterns are compared against a behavioural model on every cycle.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int NUM_BANKS    = 6;
  localparam int NUM_PERIPH   = 3;
  localparam int NUM_CORES    = 4;
  localparam int CORE_W       = 28;
  localparam int SEL_W        = 3;
  localparam int NIB_W        = SEL_W + 1;
  localparam int PINS_PER_REG = 8;
  localparam int REG_W        = NIB_W * PINS_PER_REG;
  // Bank whose pins continue the core port after bank 0
  localparam int FOLD_BANK    = 5;

  function automatic int bankSize(input int b);
    case (b)
      0:       return 16;
      1:       return 28;
      2, 3, 4: return 24;
      5:       return 10;
      default: return 0;
    endcase
  endfunction

  function automatic int bankBase(input int b);
    int s = 0;
    for (int i = 0; i < b; i++) s += bankSize(i);
    return s;
  endfunction

  localparam int NUM_PADS = bankBase(NUM_BANKS);
  localparam int NUM_REGS = (NUM_PADS + PINS_PER_REG - 1) / PINS_PER_REG;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  function automatic int padBank(input int p);
    int b = 0;
    for (int i = 1; i < NUM_BANKS; i++) if (p >= bankBase(i)) b = i;
    return b;
  endfunction

  function automatic int padCoreIdx(input int p);
    int b = padBank(p);
    int n = p - bankBase(b);
    return (b == FOLD_BANK) ? n + bankSize(0) : n;
  endfunction

  function automatic logic [REG_W-1:0] selMask();
    logic [REG_W-1:0] m = '0;
    for (int i = 0; i < PINS_PER_REG; i++) m[i*NIB_W +: SEL_W] = '1;
    return m;
  endfunction

  // Strobes from the register decode to the routing datapath
  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] grp;
    logic [REG_W-1:0]  data;
  } cfg_cmd_t;

endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfgWe,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [REG_W-1:0]          cfgWrData,
  input  logic [NUM_PADS*NIB_W-1:0] selFlat,
  output cfg_cmd_t                  cmd,
  output logic [REG_W-1:0]          cfgRdData
);

  localparam logic [REG_W-1:0] SEL_MASK = selMask();

  always_comb begin
    cmd.wrStb = cfgWe;
    cmd.grp   = cfgAddr;
    cmd.data  = cfgWrData & SEL_MASK;
  end

  always_comb begin
    int pad;
    cfgRdData = '0;
    for (int i = 0; i < PINS_PER_REG; i++) begin
      pad = int'(cfgAddr) * PINS_PER_REG + i;
      if (pad < NUM_PADS) cfgRdData[i*NIB_W +: NIB_W] = selFlat[pad*NIB_W +: NIB_W];
    end
  end

  // R2: reserved nibble bits never read back as one
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRdData & ~SEL_MASK) == '0);

endmodule

// File: rtl/pinmux_dp.sv
module pinmux_dp
  import pinmux_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  cfg_cmd_t                       cmd,
  input  logic [NUM_PADS-1:0]            gpioOut,
  input  logic [NUM_PADS-1:0]            gpioOe,
  output logic [NUM_PADS-1:0]            gpioIn,
  input  logic [NUM_PERIPH*NUM_PADS-1:0] perOut,
  input  logic [NUM_PERIPH*NUM_PADS-1:0] perOe,
  output logic [NUM_PERIPH*NUM_PADS-1:0] perIn,
  input  logic [NUM_CORES*CORE_W-1:0]    coreOut,
  input  logic [NUM_CORES*CORE_W-1:0]    coreOe,
  output logic [NUM_CORES*CORE_W-1:0]    coreIn,
  input  logic [NUM_PADS-1:0]            padIn,
  output logic [NUM_PADS-1:0]            padOut,
  output logic [NUM_PADS-1:0]            padOe,
  output logic [NUM_PADS*NIB_W-1:0]      selFlat
);

  logic [NUM_PERIPH-1:0][NUM_PADS-1:0] perOutA, perOeA, perInA;
  logic [NUM_CORES-1:0][CORE_W-1:0]    coreOutA, coreOeA, coreInA;
  logic [NUM_CORES-1:0]                coreClaimed;

  assign perOutA  = perOut;
  assign perOeA   = perOe;
  assign coreOutA = coreOut;
  assign coreOeA  = coreOe;
  assign perIn    = perInA;
  assign coreIn   = coreInA;
  assign gpioIn   = padIn;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int GRP  = p / PINS_PER_REG;
    localparam int SLOT = p % PINS_PER_REG;
    localparam int CI   = padCoreIdx(p);

    logic [NIB_W-1:0]      selR;
    logic [SEL_W-1:0]      s;
    logic                  outBit, oeBit;
    logic [NUM_PERIPH-1:0] perCol;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           selR <= '0;
      else if (cmd.wrStb && cmd.grp == ADDR_W'(GRP))        selR <= cmd.data[SLOT*NIB_W +: NIB_W];
    end

    assign s = selR[SEL_W-1:0];
    assign selFlat[p*NIB_W +: NIB_W] = selR;

    always_comb begin
      if (s[SEL_W-1]) begin
        outBit = coreOutA[s[SEL_W-2:0]][CI];
        oeBit  = coreOeA[s[SEL_W-2:0]][CI];
      end else if (s == '0) begin
        outBit = gpioOut[p];
        oeBit  = gpioOe[p];
      end else begin
        outBit = perOutA[s[SEL_W-2:0] - 1'b1][p];
        oeBit  = perOeA[s[SEL_W-2:0] - 1'b1][p];
      end
    end

    assign padOut[p] = outBit;
    assign padOe[p]  = oeBit;

    for (genvar f = 0; f < NUM_PERIPH; f++) begin : g_fn
      assign perInA[f][p] = padIn[p] && (s == SEL_W'(f + 1));
      assign perCol[f]    = perInA[f][p];
    end

    // R4: a pad left on GPIO mirrors the GPIO block exactly
    p_gpio_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s == '0) |-> (padOut[p] == gpioOut[p] && padOe[p] == gpioOe[p]));

    // R6: a pad given to a core follows that core's port bit
    p_core_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s[SEL_W-1] |-> (padOe[p] == coreOeA[s[SEL_W-2:0]][CI] &&
                      padOut[p] == coreOutA[s[SEL_W-2:0]][CI]));

    // R5: a pad level reaches at most one peripheral function
    p_per_in_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(perCol));
  end

  // Core input: scan from the highest pad down so the lowest bank is written last
  always_comb begin
    logic [SEL_W-1:0] sv;
    coreInA     = '0;
    coreClaimed = '0;
    for (int p = NUM_PADS - 1; p >= 0; p--) begin
      sv = selFlat[p*NIB_W +: SEL_W];
      if (sv[SEL_W-1]) begin
        coreInA[sv[SEL_W-2:0]][padCoreIdx(p)] = padIn[p];
        coreClaimed[sv[SEL_W-2:0]]            = 1'b1;
      end
    end
  end

  // R2: selects move only on a write strobe
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.wrStb |=> $stable(selFlat));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R8: a core no pad selects reads all zero
    p_core_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !coreClaimed[c] |-> (coreInA[c] == '0));
  end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfgWe,
  input  logic [ADDR_W-1:0]              cfgAddr,
  input  logic [REG_W-1:0]               cfgWrData,
  output logic [REG_W-1:0]               cfgRdData,
  input  logic [NUM_PADS-1:0]            gpioOut,
  input  logic [NUM_PADS-1:0]            gpioOe,
  output logic [NUM_PADS-1:0]            gpioIn,
  input  logic [NUM_PERIPH*NUM_PADS-1:0] perOut,
  input  logic [NUM_PERIPH*NUM_PADS-1:0] perOe,
  output logic [NUM_PERIPH*NUM_PADS-1:0] perIn,
  input  logic [NUM_CORES*CORE_W-1:0]    coreOut,
  input  logic [NUM_CORES*CORE_W-1:0]    coreOe,
  output logic [NUM_CORES*CORE_W-1:0]    coreIn,
  input  logic [NUM_PADS-1:0]            padIn,
  output logic [NUM_PADS-1:0]            padOut,
  output logic [NUM_PADS-1:0]            padOe
);

  cfg_cmd_t                  cmd;
  logic [NUM_PADS*NIB_W-1:0] selFlat;

  pinmux_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .selFlat   (selFlat),
    .cmd       (cmd),
    .cfgRdData (cfgRdData)
  );

  pinmux_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .gpioOut (gpioOut),
    .gpioOe  (gpioOe),
    .gpioIn  (gpioIn),
    .perOut  (perOut),
    .perOe   (perOe),
    .perIn   (perIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .coreIn  (coreIn),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .selFlat (selFlat)
  );

endmodule

// File: tb/pinmux_top_tb_top.sv
module pinmux_top_tb_top;

  localparam int NP = 126;
  localparam int NC = 4;
  localparam int CW = 28;

  logic clk = 0;
  logic rst_n = 0;
  logic cfgWe = 0;
  logic [3:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [NP-1:0] gpioOut = '0, gpioOe = '0, gpioIn;
  logic [3*NP-1:0] perOut = '0, perOe = '0, perIn;
  logic [NC*CW-1:0] coreOut = '0, coreOe = '0, coreIn;
  logic [NP-1:0] padIn = '0, padOut, padOe;

  int checks = 0;
  int failures = 0;
  bit live = 0;
  bit holdPads = 0;
  bit done = 0;
  int mSel [NP];

  always #5 clk = ~clk;

  pinmux_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .gpioIn(gpioIn),
    .perOut(perOut), .perOe(perOe), .perIn(perIn),
    .coreOut(coreOut), .coreOe(coreOe), .coreIn(coreIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe));

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference mapping written from the bank table
  function automatic int refIdx(input int p);
    if (p < 16) return p;
    if (p < 44) return p - 16;
    if (p < 68) return p - 44;
    if (p < 92) return p - 68;
    if (p < 116) return p - 92;
    return p - 116 + 16;
  endfunction

  function automatic bit refOut(input int p, input bit isOe);
    int s = mSel[p];
    if (s == 0) return isOe ? gpioOe[p] : gpioOut[p];
    if (s < 4)  return isOe ? perOe[(s-1)*NP + p] : perOut[(s-1)*NP + p];
    return isOe ? coreOe[(s-4)*CW + refIdx(p)] : coreOut[(s-4)*CW + refIdx(p)];
  endfunction

  function automatic bit refCoreIn(input int c, input int k);
    int bases [6] = '{0, 16, 44, 68, 92, 116};
    int sizes [6] = '{16, 28, 24, 24, 24, 10};
    int offs  [6] = '{0, 0, 0, 0, 0, 16};
    for (int b = 0; b < 6; b++) begin
      int n = k - offs[b];
      if (n >= 0 && n < sizes[b] && mSel[bases[b] + n] == 4 + c) return padIn[bases[b] + n];
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] refReg(input int g);
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) if (g*8 + i < NP) v[i*4 +: 3] = 3'(mSel[g*8 + i]);
    return v;
  endfunction

  task automatic writeCfg(input int g, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1; cfgAddr = 4'(g); cfgWrData = d;
    @(posedge clk);
    for (int i = 0; i < 8; i++) if (g*8 + i < NP) mSel[g*8 + i] = int'(d[i*4 +: 3]);
    #1 cfgWe = 0;
  endtask

  task automatic setPin(input int p, input int v);
    logic [31:0] d;
    int g = p / 8;
    d = refReg(g);
    d[(p % 8)*4 +: 3] = 3'(v);
    writeCfg(g, d);
  endtask

  task automatic settle();
    @(negedge clk);
    #3;
  endtask

  // Random stimulus on all data inputs
  always @(negedge clk) begin
    if (live) begin
      gpioOut = rnd(); gpioOe = rnd();
      perOut = rnd();  perOe = rnd();
      coreOut = rnd(); coreOe = rnd();
      if (!holdPads) padIn = rnd();
    end
  end

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    #3;
    if (live && rst_n) begin
      logic [NP-1:0] eOut, eOe;
      logic [3*NP-1:0] ePer;
      logic [NC*CW-1:0] eCore;
      for (int p = 0; p < NP; p++) begin
        eOut[p] = refOut(p, 1'b0);
        eOe[p]  = refOut(p, 1'b1);
        for (int f = 0; f < 3; f++) ePer[f*NP + p] = padIn[p] && (mSel[p] == f + 1);
      end
      for (int c = 0; c < NC; c++)
        for (int k = 0; k < CW; k++) eCore[c*CW + k] = refCoreIn(c, k);
      check(padOut == eOut, "R4 R5 R6 R7 padOut", padOut, eOut);
      check(padOe == eOe, "R4 R5 R6 R7 padOe", padOe, eOe);
      check(gpioIn == padIn, "R4 gpioIn", gpioIn, padIn);
      check(perIn == ePer, "R5 perIn", perIn, ePer);
      check(coreIn == eCore, "R8 coreIn", coreIn, eCore);
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) mSel[p] = 0;
    gpioOut = rnd();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(padOe == '0, "R1 padOe in reset", padOe, '0);
    check(padOut == gpioOut, "R1 padOut in reset", padOut, gpioOut);
    rst_n = 1;
    for (int g = 0; g < 16; g++) begin
      @(negedge clk); cfgAddr = 4'(g); #2;
      check(cfgRdData == 32'h0, "R1 readback after reset", cfgRdData, 32'h0);
    end

    // R2: write edge timing and reserved bits
    @(negedge clk);
    cfgWe = 1; cfgAddr = 4'd3; cfgWrData = 32'hFFFF_FFFF;
    #2 check(cfgRdData == 32'h0, "R2 before write edge", cfgRdData, 32'h0);
    @(posedge clk);
    for (int i = 0; i < 8; i++) mSel[24 + i] = 7;
    #1 cfgWe = 0;
    #1 check(cfgRdData == 32'h7777_7777, "R2 after write edge", cfgRdData, 32'h7777_7777);

    // R3: last register has six pads
    writeCfg(15, 32'hFFFF_FFFF);
    #1 cfgAddr = 4'd15;
    #1 check(cfgRdData == 32'h0077_7777, "R3 last register", cfgRdData, 32'h0077_7777);

    // Random select patterns
    live = 1;
    for (int r = 0; r < 40; r++) begin
      for (int g = 0; g < 16; g++) writeCfg(g, rnd());
      for (int g = 0; g < 16; g++) begin
        @(negedge clk); cfgAddr = 4'(g); #2;
        check(cfgRdData == refReg(g), "R2 readback", cfgRdData, refReg(g));
      end
      repeat (20) @(posedge clk);
    end

    // Index collisions on core 0, index 5: A5, B5, C5
    for (int g = 0; g < 16; g++) writeCfg(g, 32'h0);
    holdPads = 1;
    setPin(5, 4); setPin(21, 4); setPin(49, 4);
    @(negedge clk); padIn = '1; padIn[5] = 0; #3;
    check(coreIn[5] == 1'b0, "R8 lowest bank wins (A5=0)", coreIn[5], 1'b0);
    @(negedge clk); padIn = '0; padIn[5] = 1; #3;
    check(coreIn[5] == 1'b1, "R8 lowest bank wins (A5=1)", coreIn[5], 1'b1);
    setPin(5, 0);
    @(negedge clk); padIn = '0; padIn[21] = 1; #3;
    check(coreIn[5] == 1'b1, "R8 B5 wins once A5 released", coreIn[5], 1'b1);
    @(negedge clk); padIn = '1; #3;
    check(coreIn[CW +: CW] == '0, "R8 unselected core reads 0", coreIn[CW +: CW], '0);

    // B26 to core 1 index 26, F3 to core 2 index 19
    setPin(42, 5); setPin(119, 6);
    @(negedge clk); padIn = '0; padIn[42] = 1; padIn[119] = 1; #3;
    check(coreIn[CW + 26] == 1'b1, "R7 B26 at core index 26", coreIn[CW + 26], 1'b1);
    check(coreIn[2*CW + 19] == 1'b1, "R7 F3 at core index 19", coreIn[2*CW + 19], 1'b1);
    check(padOut[119] == coreOut[2*CW + 19], "R6 F3 output from core index 19",
          padOut[119], coreOut[2*CW + 19]);

    // Peripheral function 1 on pad 30
    setPin(30, 2);
    @(negedge clk); padIn = '0; padIn[30] = 1; #3;
    check(perIn[NP + 30] == 1'b1 && perIn[30] == 1'b0, "R5 perIn gated by select",
          {perIn[NP + 30], perIn[30]}, 2'b10);
    check(padOut[30] == perOut[NP + 30], "R5 pad from function 1", padOut[30], perOut[NP + 30]);

    // 24-bit bus on core 3 from A0-A15 and C16-C23
    holdPads = 0;
    for (int p = 0; p < 16; p++) setPin(p, 7);
    for (int p = 60; p < 68; p++) setPin(p, 7);
    settle();
    begin
      logic [23:0] bus;
      for (int k = 0; k < 16; k++) bus[k] = padOut[k];
      for (int k = 16; k < 24; k++) bus[k] = padOut[44 + k];
      check(bus == coreOut[3*CW +: 24], "R7 contiguous 24-bit core bus", bus, coreOut[3*CW +: 24]);
    end
    repeat (10) @(posedge clk);

    live = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule